// File: doc/BRIEF.md
# ATA DMA Channel Control Registers

This block is the host-facing register file of a two-channel, packet-driven ATA DMA engine. A simple memory-mapped bus reads and writes each channel's control word, event status byte, descriptor count, next-descriptor pointer and the two FIFO thresholds. A single global lock byte arms the start mechanism for all channels. Downstream, each channel gets a one-cycle start strobe, a level engine-reset, a two-bit PIO mode and an interrupt line.

Engine events (bus error, unexpected device interrupt, packet finished) arrive as single-cycle flags. They collect in the status byte until software reads it, and a read clears them. Software starts a packet by writing the go bit into the control word. The start takes effect only once the lock byte holds its key value, and only while the channel is not already running a packet.

Top module: `ata_dma_ctl_regs`

## Requirements
- R1: Channel n occupies a 32-byte window at 0x80 + n*0x20. Its offsets are: control at 0x00 (16-bit), status at 0x02 (8-bit), descriptor count at 0x04 (16-bit), next-descriptor pointer at 0x0C (32-bit), input FIFO threshold at 0x14 (16-bit), output FIFO threshold at 0x16 (16-bit). The lock byte is at 0xC7. A read returns its value zero-extended on `bus_rdata`, with `bus_rvalid` high, in the cycle after the access. Unmapped addresses read 0 and ignore writes.
- R2: After reset, control reads 0x0103, status 0, count 1, pointer 0, both thresholds 0x0100 and the lock byte 0.
- R3: Control bit 8 is the interrupt mask and bit 5 is the engine-reset bit. Bits 1:0 drive `pio_mode` (3 selects mode 4). Bit 7 (go) and all other bits read back as 0.
- R4: A control write with bit 7 set produces `start_pulse[n]` high for exactly the one cycle after the write, but only if the lock byte held 7 when the write happened.
- R5: A go write is ignored while the channel is busy. The channel is busy from an accepted start until a packet-finished or bus-error event. A go write is also ignored while the reset bit is set, either already in the register or in the same write.
- R6: `eng_reset[n]` follows control bit 5. While it is set, the status byte is cleared, incoming events are dropped and busy is cleared. Pointer, count and thresholds keep their values.
- R7: Event flag 3n+0 sets status bit 0 (bus error), 3n+1 sets bit 4 (unexpected interrupt) and 3n+2 sets bit 6 (packet finished). Bits stay set until a status read, which returns them and clears them. An event arriving in the same cycle as the read survives into the next value.
- R8: `irq[n]` is high when the status byte is non-zero and the mask bit is clear.
- R9: The channels are independent: accesses and events on one channel change nothing on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data, right-aligned to the register width |
| bus_rdata | output | 32 | Read data, zero-extended, one cycle after the read |
| bus_rvalid | output | 1 | High in the cycle that `bus_rdata` carries a read result |
| evt_flags | input | 6 | Per-channel event strobes, three per channel |
| start_pulse | output | 2 | One-cycle packet start per channel |
| eng_reset | output | 2 | Engine reset level per channel |
| irq | output | 2 | Interrupt request per channel |
| pio_mode | output | 4 | Two-bit PIO mode per channel |

## Verification
The assertions assume that the host makes at most one access per cycle and that event strobes last a single cycle. They also assume that reset holds long enough to clear every register, so that a start strobe can always be traced back to a lock value seen in the previous cycle. The stimulus drives one access per cycle at most, pulses events for one cycle each, and mixes go writes with reset writes and lock rewrites to other values. This keeps busy, reset and lock conditions overlapping within those assumptions.

// File: rtl/ata_dma_ctl_pkg.sv
package ata_dma_ctl_pkg;

    // register offsets inside a channel window
    localparam logic [4:0] OFF_CTL  = 5'h00;
    localparam logic [4:0] OFF_STAT = 5'h02;
    localparam logic [4:0] OFF_CNT  = 5'h04;
    localparam logic [4:0] OFF_NPTR = 5'h0C;
    localparam logic [4:0] OFF_FIN  = 5'h14;
    localparam logic [4:0] OFF_FOUT = 5'h16;

    // control word bit positions
    localparam int CB_MASK = 8;
    localparam int CB_GO   = 7;
    localparam int CB_RST  = 5;

    // event strobe index within a channel's three flags
    localparam int EV_BUSERR = 0;
    localparam int EV_UNEXP  = 1;
    localparam int EV_DONE   = 2;

    localparam logic [15:0] CNT_INIT  = 16'd1;
    localparam logic [15:0] FIFO_INIT = 16'h0100;
    localparam logic [1:0]  PIO_INIT  = 2'd3;

    typedef struct packed {
        logic       mask;
        logic       rst;
        logic [1:0] pio;
    } ctl_t;

    function automatic logic [15:0] ctl_image(input ctl_t c);
        logic [15:0] img;
        img          = '0;
        img[CB_MASK] = c.mask;
        img[CB_RST]  = c.rst;
        img[1:0]     = c.pio;
        return img;
    endfunction

    function automatic logic [7:0] evt_image(input logic [2:0] e);
        logic [7:0] s;
        s    = '0;
        s[0] = e[EV_BUSERR];
        s[4] = e[EV_UNEXP];
        s[6] = e[EV_DONE];
        return s;
    endfunction

endpackage

// File: rtl/ata_dma_chan.sv
module ata_dma_chan
    import ata_dma_ctl_pkg::*;
#(
    parameter int OFFW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic            rd,
    input  logic [OFFW-1:0] offs,
    input  logic [31:0]     wdata,
    input  logic            lock_ok,
    input  logic [2:0]      evt,
    output logic [31:0]     rdata,
    output logic            start_pulse,
    output logic            eng_reset,
    output logic            irq,
    output logic [1:0]      pio_mode
);

    ctl_t        ctl;
    logic [7:0]  status;
    logic [15:0] desc_cnt;
    logic [31:0] next_ptr;
    logic [15:0] fifo_in_thr;
    logic [15:0] fifo_out_thr;
    logic        busy;

    logic wr_ctl, rd_stat, start_req, stop_evt;

    assign wr_ctl    = wr && (offs == OFFW'(OFF_CTL));
    assign rd_stat   = rd && (offs == OFFW'(OFF_STAT));
    assign start_req = wr_ctl && wdata[CB_GO] && lock_ok && !busy
                       && !ctl.rst && !wdata[CB_RST];
    assign stop_evt  = evt[EV_DONE] || evt[EV_BUSERR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl          <= '{mask: 1'b1, rst: 1'b0, pio: PIO_INIT};
            status       <= '0;
            desc_cnt     <= CNT_INIT;
            next_ptr     <= '0;
            fifo_in_thr  <= FIFO_INIT;
            fifo_out_thr <= FIFO_INIT;
            busy         <= 1'b0;
            start_pulse  <= 1'b0;
        end else begin
            start_pulse <= start_req;
            if (ctl.rst) begin
                status <= '0;
                busy   <= 1'b0;
            end else begin
                status <= (rd_stat ? 8'h00 : status) | evt_image(evt);
                if (start_req)
                    busy <= 1'b1;
                else if (stop_evt)
                    busy <= 1'b0;
            end
            if (wr_ctl) begin
                ctl.mask <= wdata[CB_MASK];
                ctl.rst  <= wdata[CB_RST];
                ctl.pio  <= wdata[1:0];
            end
            if (wr && offs == OFFW'(OFF_CNT))  desc_cnt     <= wdata[15:0];
            if (wr && offs == OFFW'(OFF_NPTR)) next_ptr     <= wdata;
            if (wr && offs == OFFW'(OFF_FIN))  fifo_in_thr  <= wdata[15:0];
            if (wr && offs == OFFW'(OFF_FOUT)) fifo_out_thr <= wdata[15:0];
        end
    end

    always_comb begin
        case (offs)
            OFFW'(OFF_CTL):  rdata = {16'h0, ctl_image(ctl)};
            OFFW'(OFF_STAT): rdata = {24'h0, status};
            OFFW'(OFF_CNT):  rdata = {16'h0, desc_cnt};
            OFFW'(OFF_NPTR): rdata = next_ptr;
            OFFW'(OFF_FIN):  rdata = {16'h0, fifo_in_thr};
            OFFW'(OFF_FOUT): rdata = {16'h0, fifo_out_thr};
            default:         rdata = '0;
        endcase
    end

    assign eng_reset = ctl.rst;
    assign irq       = (status != 8'h00) && !ctl.mask;
    assign pio_mode  = ctl.pio;

endmodule

// File: rtl/ata_dma_rdmux.sv
module ata_dma_rdmux #(
    parameter int NCH = 2,
    parameter int DW  = 32
) (
    input  logic [NCH-1:0]         ch_hit,
    input  logic [NCH-1:0][DW-1:0] ch_data,
    input  logic                   lock_hit,
    input  logic [7:0]             lock_val,
    output logic [DW-1:0]          data
);

    always_comb begin
        data = lock_hit ? DW'(lock_val) : '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i])
                data = data | ch_data[i];
        end
    end

endmodule

// File: rtl/ata_dma_ctl_regs.sv
module ata_dma_ctl_regs
    import ata_dma_ctl_pkg::*;
#(
    parameter int             NCH       = 2,
    parameter int             AW        = 8,
    parameter int             CH_BASE   = 'h80,
    parameter int             CH_STRIDE = 'h20,
    parameter logic [AW-1:0]  LOCK_ADDR = 8'hC7,
    parameter logic [7:0]     LOCK_KEY  = 8'h07
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    input  logic [3*NCH-1:0] evt_flags,
    output logic [NCH-1:0]   start_pulse,
    output logic [NCH-1:0]   eng_reset,
    output logic [NCH-1:0]   irq,
    output logic [2*NCH-1:0] pio_mode
);

    localparam int OFFW = $clog2(CH_STRIDE);

    logic [NCH-1:0]           ch_hit;
    logic [NCH-1:0][OFFW-1:0] ch_off;
    logic [NCH-1:0][31:0]     ch_data;
    logic                     lock_hit;
    logic [7:0]               lock_q;
    logic                     lock_ok;
    logic                     is_rd, is_wr;
    logic [31:0]              mux_data;

    assign is_rd    = bus_valid && !bus_write;
    assign is_wr    = bus_valid && bus_write;
    assign lock_hit = (bus_addr == LOCK_ADDR);
    assign lock_ok  = (lock_q == LOCK_KEY);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [AW:0] LO = (AW+1)'(CH_BASE + g * CH_STRIDE);
        localparam logic [AW:0] HI = (AW+1)'(CH_BASE + (g + 1) * CH_STRIDE);

        assign ch_hit[g] = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);
        assign ch_off[g] = OFFW'(bus_addr - LO[AW-1:0]);

        ata_dma_chan #(.OFFW(OFFW)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .wr          (is_wr && ch_hit[g]),
            .rd          (is_rd && ch_hit[g]),
            .offs        (ch_off[g]),
            .wdata       (bus_wdata),
            .lock_ok     (lock_ok),
            .evt         (evt_flags[3*g +: 3]),
            .rdata       (ch_data[g]),
            .start_pulse (start_pulse[g]),
            .eng_reset   (eng_reset[g]),
            .irq         (irq[g]),
            .pio_mode    (pio_mode[2*g +: 2])
        );
    end

    ata_dma_rdmux #(.NCH(NCH), .DW(32)) u_rdmux (
        .ch_hit   (ch_hit),
        .ch_data  (ch_data),
        .lock_hit (lock_hit),
        .lock_val (lock_q),
        .data     (mux_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q     <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            if (is_wr && lock_hit)
                lock_q <= bus_wdata[7:0];
            bus_rvalid <= is_rd;
            bus_rdata  <= is_rd ? mux_data : '0;
        end
    end

endmodule

// File: rtl/ata_dma_ctl_chk.sv
module ata_dma_ctl_chk #(
    parameter int         NCH      = 2,
    parameter logic [7:0] LOCK_KEY = 8'h07
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_valid,
    input logic           bus_write,
    input logic           bus_rvalid,
    input logic [7:0]     lock_q,
    input logic [NCH-1:0] start_pulse,
    input logic [NCH-1:0] eng_reset,
    input logic [NCH-1:0] irq
);

    p_rvalid_follows_read_r1: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
            start_pulse[g] |=> !start_pulse[g]);

        p_start_needs_key_r4: assert property (@(posedge clk) disable iff (rst)
            start_pulse[g] |-> ($past(lock_q) == LOCK_KEY));

        p_no_start_in_reset_r5: assert property (@(posedge clk) disable iff (rst)
            eng_reset[g] |-> !start_pulse[g]);

        p_quiet_in_reset_r6: assert property (@(posedge clk) disable iff (rst)
            (eng_reset[g] && $past(eng_reset[g])) |-> !irq[g]);
    end

endmodule

bind ata_dma_ctl_regs ata_dma_ctl_chk #(.NCH(NCH), .LOCK_KEY(LOCK_KEY)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_rvalid  (bus_rvalid),
    .lock_q      (lock_q),
    .start_pulse (start_pulse),
    .eng_reset   (eng_reset),
    .irq         (irq)
);

// File: tb/sim_ata_dma_ctl_regs.sv
`timescale 1ns/1ps
module sim_ata_dma_ctl_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [5:0]  evt_flags = '0;
    logic [1:0]  start_pulse, eng_reset, irq;
    logic [3:0]  pio_mode;

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ata_dma_ctl_regs u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .evt_flags(evt_flags), .start_pulse(start_pulse),
        .eng_reset(eng_reset), .irq(irq), .pio_mode(pio_mode)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_mask[2], m_rstb[2], m_busy[2], m_start[2];
    int          m_pio[2];
    logic [7:0]  m_st[2];
    logic [15:0] m_cnt[2], m_fin[2], m_fout[2];
    logic [31:0] m_ptr[2];
    logic [7:0]  m_lock;
    logic [31:0] m_rdata;
    bit          m_rv;

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_mask[c] = 1; m_rstb[c] = 0; m_busy[c] = 0; m_start[c] = 0;
                m_pio[c] = 3; m_st[c] = 0; m_cnt[c] = 1; m_ptr[c] = 0;
                m_fin[c] = 16'h100; m_fout[c] = 16'h100;
            end
            m_lock = 0; m_rdata = 0; m_rv = 0;
        end else begin
            automatic bit rdq = bus_valid && !bus_write;
            automatic bit wrq = bus_valid && bus_write;
            automatic logic [31:0] rv = 0;
            if (bus_addr == 8'hC7) rv = {24'h0, m_lock};
            for (int c = 0; c < 2; c++) begin
                automatic int base = 'h80 + c * 'h20;
                automatic bit hit = (bus_addr >= base) && (bus_addr < base + 'h20);
                automatic int off = bus_addr - base;
                automatic logic [2:0] e = evt_flags[3*c +: 3];
                automatic logic [7:0] eb = {1'b0, e[2], 1'b0, e[1], 3'b000, e[0]};
                automatic bit go;
                if (rdq && hit) begin
                    case (off)
                        0:    rv = (m_mask[c] ? 32'h100 : 0) | (m_rstb[c] ? 32'h20 : 0) | m_pio[c];
                        2:    rv = {24'h0, m_st[c]};
                        4:    rv = {16'h0, m_cnt[c]};
                        12:   rv = m_ptr[c];
                        20:   rv = {16'h0, m_fin[c]};
                        22:   rv = {16'h0, m_fout[c]};
                        default: rv = 0;
                    endcase
                end
                go = wrq && hit && off == 0 && bus_wdata[7] && m_lock == 8'h07
                     && !m_busy[c] && !m_rstb[c] && !bus_wdata[5];
                if (m_rstb[c]) begin
                    m_st[c] = 0; m_busy[c] = 0;
                end else begin
                    m_st[c] = ((rdq && hit && off == 2) ? 8'h00 : m_st[c]) | eb;
                    if (go) m_busy[c] = 1;
                    else if (e[2] || e[0]) m_busy[c] = 0;
                end
                m_start[c] = go;
                if (wrq && hit) begin
                    case (off)
                        0: begin m_mask[c] = bus_wdata[8]; m_rstb[c] = bus_wdata[5]; m_pio[c] = int'(bus_wdata[1:0]); end
                        4:  m_cnt[c] = bus_wdata[15:0];
                        12: m_ptr[c] = bus_wdata;
                        20: m_fin[c] = bus_wdata[15:0];
                        22: m_fout[c] = bus_wdata[15:0];
                        default: ;
                    endcase
                end
            end
            if (wrq && bus_addr == 8'hC7) m_lock = bus_wdata[7:0];
            m_rv = rdq;
            m_rdata = rdq ? rv : 0;
        end
    end

    function automatic void check(input bit ok, input string tag,
                                  input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endfunction

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            for (int c = 0; c < 2; c++) begin
                check(start_pulse[c] == m_start[c], "R4 start_pulse", 32'(start_pulse[c]), 32'(m_start[c]));
                check(eng_reset[c] == m_rstb[c], "R6 eng_reset", 32'(eng_reset[c]), 32'(m_rstb[c]));
                check(irq[c] == ((m_st[c] != 0) && !m_mask[c]), "R8 irq",
                      32'(irq[c]), 32'((m_st[c] != 0) && !m_mask[c]));
                check(int'(pio_mode[2*c +: 2]) == m_pio[c], "R3 pio_mode",
                      32'(pio_mode[2*c +: 2]), 32'(m_pio[c]));
            end
            check(bus_rvalid == m_rv, "R1 rvalid", 32'(bus_rvalid), 32'(m_rv));
            check(bus_rdata == m_rdata, "R7 rdata", bus_rdata, m_rdata);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        check(bus_rvalid == 1'b1 && bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic do_evt(input int c, input logic [2:0] e);
        @(negedge clk);
        evt_flags[3*c +: 3] = e;
        @(negedge clk);
        evt_flags = '0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=done");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk_on = 1;

        // R2 reset values
        do_rd(8'h80, 32'h0103, "R2 ctl reset");
        do_rd(8'h82, 32'h0, "R2 status reset");
        do_rd(8'h84, 32'h1, "R2 count reset");
        do_rd(8'h8C, 32'h0, "R2 pointer reset");
        do_rd(8'h94, 32'h100, "R2 fifo-in reset");
        do_rd(8'h96, 32'h100, "R2 fifo-out reset");
        do_rd(8'hA0, 32'h0103, "R2 ctl1 reset");
        do_rd(8'hC7, 32'h0, "R2 lock reset");

        // R4 go without key
        do_wr(8'h80, 32'h0083);
        check(start_pulse == 2'b00, "R4 go without key", 32'(start_pulse), 0);
        do_wr(8'hC7, 32'h07);
        do_rd(8'hC7, 32'h07, "R1 lock readback");
        do_wr(8'h80, 32'h0083);
        check(start_pulse == 2'b01, "R4 go with key", 32'(start_pulse), 1);
        @(negedge clk);
        check(start_pulse == 2'b00, "R4 single cycle", 32'(start_pulse), 0);
        do_rd(8'h80, 32'h0003, "R3 go reads zero");

        // R5 busy
        do_wr(8'h80, 32'h0083);
        check(start_pulse == 2'b00, "R5 go while busy", 32'(start_pulse), 0);
        do_evt(0, 3'b100);
        check(irq == 2'b01, "R8 irq on done", 32'(irq), 1);
        do_wr(8'h80, 32'h0083);
        check(start_pulse == 2'b01, "R5 go after done", 32'(start_pulse), 1);

        // R7 read-clear
        do_rd(8'h82, 32'h40, "R7 status done bit");
        check(irq == 2'b00, "R7 irq after clear", 32'(irq), 0);
        do_rd(8'h82, 32'h0, "R7 status cleared");
        do_evt(0, 3'b001);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 8'h82; evt_flags = 6'b000010;
        @(negedge clk);
        bus_valid = 0; evt_flags = '0;
        check(bus_rdata == 32'h01, "R7 read with event", bus_rdata, 32'h01);
        do_rd(8'h82, 32'h10, "R7 event survives read");

        // R6 reset bit holds state
        do_wr(8'h8C, 32'hDEADBEEF);
        do_wr(8'h84, 32'h0005);
        do_wr(8'h94, 32'h0040);
        do_wr(8'h80, 32'h01A2);
        check(start_pulse == 2'b00, "R5 go with reset bit", 32'(start_pulse), 0);
        check(eng_reset == 2'b01, "R6 eng_reset set", 32'(eng_reset), 1);
        check(pio_mode[1:0] == 2'd2, "R3 pio field", 32'(pio_mode[1:0]), 2);
        do_rd(8'h80, 32'h0122, "R3 ctl readback");
        do_evt(0, 3'b111);
        do_rd(8'h82, 32'h0, "R6 events dropped in reset");
        do_wr(8'h80, 32'h0100);
        do_rd(8'h8C, 32'hDEADBEEF, "R6 pointer kept");
        do_rd(8'h84, 32'h5, "R6 count kept");
        do_rd(8'h94, 32'h40, "R6 threshold kept");

        // R8 mask
        do_evt(0, 3'b100);
        check(irq == 2'b00, "R8 masked", 32'(irq), 0);
        do_rd(8'h82, 32'h40, "R8 status while masked");

        // R9 independence
        do_wr(8'hA0, 32'h0083);
        check(start_pulse == 2'b10, "R9 channel 1 start", 32'(start_pulse), 2);
        do_evt(1, 3'b010);
        check(irq == 2'b10, "R9 channel 1 irq only", 32'(irq), 2);
        do_rd(8'h82, 32'h0, "R9 channel 0 untouched");

        // R1 unmapped
        do_rd(8'h40, 32'h0, "R1 unmapped read");
        do_wr(8'h86, 32'hFFFF);
        do_rd(8'h84, 32'h5, "R1 hole write ignored");
        do_rd(8'h86, 32'h0, "R1 hole reads zero");
        do_wr(8'hB6, 32'h1234);
        do_rd(8'hB6, 32'h1234, "R1 channel 1 fifo-out");

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            automatic int pick = $urandom_range(0, 15);
            automatic logic [7:0] a;
            automatic logic [31:0] d = $urandom;
            case (pick % 8)
                0, 1: a = 8'h80;
                2, 3: a = 8'h82;
                4: a = 8'h84;
                5: a = 8'h8C;
                6: a = 8'h96;
                default: a = 8'hC7;
            endcase
            if (pick >= 8) a = a + 8'h20;
            if (a == 8'hE7) a = 8'h40;
            if (a == 8'hC7) d = ($urandom_range(0, 3) == 0) ? d : 32'h7;
            if (a[4:0] == 5'h00) begin
                d[7] = 1'b1;
                d[5] = ($urandom_range(0, 7) == 0);
            end
            @(negedge clk);
            bus_valid = ($urandom_range(0, 3) != 0);
            bus_write = ($urandom_range(0, 2) == 0);
            bus_addr = a;
            bus_wdata = d;
            for (int b = 0; b < 6; b++)
                evt_flags[b] = ($urandom_range(0, 7) == 0);
        end
        @(negedge clk);
        bus_valid = 0; evt_flags = '0;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule